// File: doc/BRIEF.md
# Process Corner Edge-Count Classifier

This block sorts the die into one of three process corners (fast, typical, slow) using three comparator outputs. Depending on the corner, each comparator output either toggles or stays high. A start strobe opens a measurement window that lasts a programmable number of clock cycles. During the window the block counts rising edges on every comparator input. At the end of the window each count is compared with a fixed threshold, and the three resulting bits are encoded as a one-hot corner code.

The same result also selects an entry in a reference-voltage table. The table index combines three things: the requested output-voltage shift (+5 V, +7 V or +10 V), the detected corner, and a thermometer-coded temperature segment. Bit patterns and select codes that have no defined meaning clear the valid flag and leave the held results unchanged. The comparator inputs are asynchronous, so each one passes through a synchronizer before edge detection.

Top module: `corner_classifier`

## Requirements
- R1: After reset, corner_code is 000, lut_idx is 0, and both done and valid are 0.
- R2: When start is sampled high at a clock edge, done goes high for exactly one cycle, L+1 clock edges later. L is win_len, and a win_len of 0 is treated as 1.
- R3: cmp_in[i] is the i-th comparator. Its bit is high when fewer than 7 synchronized rising edges fell inside the window. A count of 7 or more gives a low bit.
- R4: Edge counters saturate at their maximum. A burst of many edges (for example 16) still yields a low bit and does not wrap back to a high bit.
- R5: The corner is decided by the bits of comparators 0, 1 and 2. All three high means fast, and corner_code is 100. Only comparator 0 low means typical, and corner_code is 010. Comparators 0 and 1 low with 2 high means slow, and corner_code is 001.
- R6: Any other bit combination holds corner_code and lut_idx at their previous values and clears valid.
- R7: For a valid measurement, lut_idx = 15*s + 5*c + t. Here s is shift_sel (0, 1 or 2), c is the corner (fast 0, typical 1, slow 2), and t is the temperature segment. The segment is tseg 0000 → 0, 1000 → 1, 1100 → 2, 1110 → 3, 1111 → 4, with bit 3 the first bit to set.
- R8: A shift_sel of 11, or a tseg that is not one of the five thermometer codes, holds lut_idx and clears valid. The corner code still updates.
- R9: A start that arrives while a window is open restarts the window and clears the counts. No done is produced for the abandoned window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle strobe that opens a measurement window |
| win_len | input | WIN_W | Window length in clock cycles (0 acts as 1) |
| cmp_in | input | 3 | Asynchronous comparator outputs, index 0 is the first comparator |
| tseg | input | 4 | Thermometer temperature segment code |
| shift_sel | input | 2 | Output-shift select: 00 +5 V, 01 +7 V, 10 +10 V |
| corner_code | output | 3 | One-hot corner: 100 fast, 010 typical, 001 slow |
| done | output | 1 | One-cycle pulse when results are latched |
| valid | output | 1 | Last measurement was fully decodable |
| lut_idx | output | IDX_W | Reference table index (6 bits by default) |

## Verification
The bench uses the default parameters: 4-bit saturating counters, a threshold of 7 and a 16-bit window length. With these values the saturation point and the threshold both sit inside a short window. The bench sweeps every combination of edge counts drawn from {0, 3, 6, 7, 8, 16} over the three inputs. This covers the threshold on both sides and the saturation point, and it reaches every valid and invalid bit pattern. A second sweep covers all sixteen tseg codes against all four shift codes, which includes the reserved ones. Directed runs cover a zero-length window and a restart in the middle of a window.

// File: rtl/corner_cls_pkg.sv
package corner_cls_pkg;
  localparam int N_CMP      = 3;
  localparam int N_SHIFT    = 3;
  localparam int N_CORNER   = 3;
  localparam int N_TSEG     = 5;
  localparam int LUT_DEPTH  = N_SHIFT * N_CORNER * N_TSEG;
  localparam int IDX_W      = $clog2(LUT_DEPTH);
  localparam int SHIFT_STEP = N_CORNER * N_TSEG;

  typedef enum logic [2:0] {
    CRN_NONE = 3'b000,
    CRN_SLOW = 3'b001,
    CRN_TYP  = 3'b010,
    CRN_FAST = 3'b100
  } corner_e;
endpackage

// File: rtl/edge_tally.sv
module edge_tally #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic             din,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 rise;

  assign rise = shreg_q[SYNC_STAGES-1] & ~shreg_q[SYNC_STAGES];

  always_comb begin
    shreg_d = {shreg_q[SYNC_STAGES-1:0], din};
    cnt_d   = cnt_q;
    if (clear)
      cnt_d = '0;
    else if (enable && rise && (cnt_q != CNT_MAX))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/window_timer.sv
module window_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIN_W-1:0] win_len,
  output logic             busy,
  output logic             fin
);
  logic [WIN_W-1:0] rem_q, rem_d;
  logic             busy_q, busy_d, fin_q, fin_d;

  always_comb begin
    rem_d  = rem_q;
    busy_d = busy_q;
    fin_d  = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      rem_d  = (win_len == '0) ? WIN_W'(1) : win_len;
    end else if (busy_q) begin
      rem_d = rem_q - 1'b1;
      if (rem_q == WIN_W'(1)) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      busy_q <= busy_d;
      fin_q  <= fin_d;
    end
  end

  assign busy = busy_q;
  assign fin  = fin_q;
endmodule

// File: rtl/corner_encoder.sv
module corner_encoder
  import corner_cls_pkg::*;
(
  input  logic [N_CMP-1:0] hi_bits,
  output corner_e          code,
  output logic [1:0]       crn_num,
  output logic             pat_ok
);
  always_comb begin
    code    = CRN_NONE;
    crn_num = 2'd0;
    pat_ok  = 1'b1;
    unique case (hi_bits)
      3'b111: begin code = CRN_FAST; crn_num = 2'd0; end
      3'b110: begin code = CRN_TYP;  crn_num = 2'd1; end
      3'b100: begin code = CRN_SLOW; crn_num = 2'd2; end
      default: pat_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/lut_index.sv
module lut_index
  import corner_cls_pkg::*;
(
  input  logic [1:0]       shift_sel,
  input  logic [3:0]       tseg,
  input  logic [1:0]       crn_num,
  output logic [IDX_W-1:0] idx,
  output logic             sel_ok
);
  logic [2:0] t_num;
  logic       t_ok;

  always_comb begin
    t_ok  = 1'b1;
    t_num = 3'd0;
    case (tseg)
      4'b0000: t_num = 3'd0;
      4'b1000: t_num = 3'd1;
      4'b1100: t_num = 3'd2;
      4'b1110: t_num = 3'd3;
      4'b1111: t_num = 3'd4;
      default: t_ok  = 1'b0;
    endcase
  end

  assign sel_ok = t_ok && (shift_sel != 2'b11);
  assign idx    = IDX_W'(int'(shift_sel) * SHIFT_STEP + int'(crn_num) * N_TSEG + int'(t_num));
endmodule

// File: rtl/corner_classifier.sv
module corner_classifier
  import corner_cls_pkg::*;
#(
  parameter int WIN_W      = 16,
  parameter int CNT_W      = 4,
  parameter int EDGE_LIMIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIN_W-1:0] win_len,
  input  logic [2:0]       cmp_in,
  input  logic [3:0]       tseg,
  input  logic [1:0]       shift_sel,
  output logic [2:0]       corner_code,
  output logic             done,
  output logic             valid,
  output logic [IDX_W-1:0] lut_idx
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic busy, fin;

  window_timer #(.WIN_W(WIN_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .start(start), .win_len(win_len),
    .busy(busy), .fin(fin)
  );

  logic [N_CMP-1:0] hi_bits;

  for (genvar g = 0; g < N_CMP; g++) begin : g_tally
    logic [CNT_W-1:0] cnt;
    edge_tally #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_tally (
      .clk(clk), .rst_n(rst_int_n), .clear(start), .enable(busy),
      .din(cmp_in[g]), .count(cnt)
    );
    assign hi_bits[g] = (int'(cnt) < EDGE_LIMIT);
  end

  corner_e          enc_code;
  logic [1:0]       crn_num;
  logic             pat_ok;
  logic [IDX_W-1:0] idx_new;
  logic             sel_ok;

  corner_encoder u_enc (
    .hi_bits(hi_bits), .code(enc_code), .crn_num(crn_num), .pat_ok(pat_ok)
  );

  lut_index u_idx (
    .shift_sel(shift_sel), .tseg(tseg), .crn_num(crn_num),
    .idx(idx_new), .sel_ok(sel_ok)
  );

  logic [2:0]       corner_q, corner_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             valid_q, valid_d, done_q, done_d;
  logic             latch_en;

  assign latch_en = fin & ~start;

  always_comb begin
    corner_d = corner_q;
    idx_d    = idx_q;
    valid_d  = valid_q;
    done_d   = latch_en;
    if (latch_en) begin
      valid_d = pat_ok && sel_ok;
      if (pat_ok)           corner_d = enc_code;
      if (pat_ok && sel_ok) idx_d    = idx_new;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      corner_q <= CRN_NONE;
      idx_q    <= '0;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      corner_q <= corner_d;
      idx_q    <= idx_d;
      valid_q  <= valid_d;
      done_q   <= done_d;
    end
  end

  assign corner_code = corner_q;
  assign lut_idx     = idx_q;
  assign valid       = valid_q;
  assign done        = done_q;
endmodule

// File: rtl/corner_classifier_chk.sv
module corner_classifier_chk
  import corner_cls_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic             valid,
  input logic [2:0]       corner_code,
  input logic [IDX_W-1:0] lut_idx
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R2: done lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a start cancels any pending completion
  a_r9_start_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  // R5: corner code is one-hot or empty
  a_r5_corner_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(corner_code));

  // R5: a valid result always carries a corner
  a_r5_valid_has_corner: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($countones(corner_code) == 1));

  // R6: results only move together with done
  a_r6_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !done) |-> ($stable(corner_code) && $stable(lut_idx) && $stable(valid)));

  // R7: index stays inside the table
  a_r7_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lut_idx) < LUT_DEPTH);
endmodule

bind corner_classifier corner_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .valid(valid),
  .corner_code(corner_code), .lut_idx(lut_idx)
);

// File: tb/corner_classifier_tb.sv
module corner_classifier_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] win_len = '0;
  logic [2:0]  cmp_in = 3'b111;
  logic [3:0]  tseg = '0;
  logic [1:0]  shift_sel = '0;
  logic [2:0]  corner_code;
  logic        done, valid;
  logic [5:0]  lut_idx;

  int n_cmp = 0;
  int n_bad = 0;

  logic [2:0] exp_corner = 3'b000;
  logic [5:0] exp_idx    = 6'd0;
  logic       exp_valid  = 1'b0;

  always #10 clk = ~clk;

  corner_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .win_len(win_len),
    .cmp_in(cmp_in), .tseg(tseg), .shift_sel(shift_sel),
    .corner_code(corner_code), .done(done), .valid(valid), .lut_idx(lut_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int tseg_num(input logic [3:0] t);
    case (t)
      4'b0000: return 0;
      4'b1000: return 1;
      4'b1100: return 2;
      4'b1110: return 3;
      4'b1111: return 4;
      default: return -1;
    endcase
  endfunction

  // model of R3..R8
  task automatic predict(input int c0, input int c1, input int c2,
                         input logic [1:0] s, input logic [3:0] t);
    logic [2:0] hb;
    int cn;
    bit pok, sok;
    hb  = {c2 < 7, c1 < 7, c0 < 7};
    pok = 1'b1;
    cn  = 0;
    case (hb)
      3'b111: begin cn = 0; exp_corner = 3'b100; end
      3'b110: begin cn = 1; exp_corner = 3'b010; end
      3'b100: begin cn = 2; exp_corner = 3'b001; end
      default: pok = 1'b0;
    endcase
    sok = (s != 2'b11) && (tseg_num(t) >= 0);
    exp_valid = pok && sok;
    if (pok && sok) exp_idx = 6'(15 * int'(s) + 5 * cn + tseg_num(t));
  endtask

  task automatic pulse_start(input int len);
    @(negedge clk);
    win_len = 16'(len);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // c0..c2 rising edges, 4 cycles per pulse
  task automatic run(input int c0, input int c1, input int c2,
                     input logic [1:0] s, input logic [3:0] t, input int len);
    int mx, leff, seen;
    int cnt[3];
    cnt[0] = c0; cnt[1] = c1; cnt[2] = c2;
    mx = c0; if (c1 > mx) mx = c1; if (c2 > mx) mx = c2;
    @(negedge clk);
    shift_sel = s;
    tseg = t;
    cmp_in = 3'b111;
    leff = (len == 0) ? 1 : len;
    win_len = 16'(len);
    start = 1'b1;
    @(posedge clk);
    seen = -1;
    for (int n = 1; n <= leff + 6; n++) begin
      @(negedge clk);
      start = 1'b0;
      if (seen < 0 && done) seen = n - 1;
      for (int i = 0; i < 3; i++)
        cmp_in[i] = !(((n - 1) / 4 < cnt[i]) && (((n - 1) % 4) < 2));
      @(posedge clk);
    end
    @(negedge clk);
    cmp_in = 3'b111;
    predict(c0, c1, c2, s, t);
    chk(seen == leff + 1, "R2 done latency", seen, leff + 1);
    chk(corner_code == exp_corner, "R3/R4/R5/R6 corner_code", int'(corner_code), int'(exp_corner));
    chk(valid == exp_valid, "R6/R8 valid", int'(valid), int'(exp_valid));
    chk(lut_idx == exp_idx, "R7/R8 lut_idx", int'(lut_idx), int'(exp_idx));
    chk(!done, "R2 done single cycle", int'(done), 0);
  endtask

  initial begin
    #(200000 * 20);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int vals[6];
    int k;
    logic [3:0] tlist[5];
    vals[0] = 0; vals[1] = 3; vals[2] = 6; vals[3] = 7; vals[4] = 8; vals[5] = 16;
    tlist[0] = 4'b0000; tlist[1] = 4'b1000; tlist[2] = 4'b1100;
    tlist[3] = 4'b1110; tlist[4] = 4'b1111;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(corner_code == 3'b000, "R1 corner_code", int'(corner_code), 0);
    chk(lut_idx == 6'd0, "R1 lut_idx", int'(lut_idx), 0);
    chk(!done, "R1 done", int'(done), 0);
    chk(!valid, "R1 valid", int'(valid), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R3 R4 R5 R6: count sweep, valid selects
    k = 0;
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int c = 0; c < 6; c++) begin
          run(vals[a], vals[b], vals[c], 2'(k % 3), tlist[k % 5], 70);
          k++;
        end

    // R7 R8: every shift and tseg code, typical corner then fast
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 16; t++)
        run(8, 0, 0, 2'(s), 4'(t), 40);
    for (int s = 0; s < 4; s++)
      run(0, 0, 0, 2'(s), 4'b1100, 8);

    // R2: zero-length window acts as one cycle
    run(0, 0, 0, 2'b01, 4'b1111, 0);
    run(0, 0, 0, 2'b10, 4'b0000, 1);

    // R9: restart mid-window clears counts, old window gives no done
    begin
      int seen, early;
      @(negedge clk);
      shift_sel = 2'b00;
      tseg = 4'b1000;
      win_len = 16'd60;
      start = 1'b1;
      @(posedge clk);
      early = 0;
      for (int n = 1; n <= 30; n++) begin
        @(negedge clk);
        start = 1'b0;
        if (done) early = 1;
        cmp_in[0] = !(((n - 1) % 4) < 2);
        @(posedge clk);
      end
      @(negedge clk);
      cmp_in = 3'b111;
      win_len = 16'd20;
      start = 1'b1;
      @(posedge clk);
      seen = -1;
      for (int n = 1; n <= 50; n++) begin
        @(negedge clk);
        start = 1'b0;
        if (seen < 0 && done) seen = n - 1;
        @(posedge clk);
      end
      @(negedge clk);
      predict(0, 0, 0, 2'b00, 4'b1000);
      chk(early == 0, "R9 no done before restart", early, 0);
      chk(seen == 21, "R9 done after restart", seen, 21);
      chk(corner_code == exp_corner, "R9 corner_code", int'(corner_code), int'(exp_corner));
      chk(lut_idx == exp_idx, "R9 lut_idx", int'(lut_idx), int'(exp_idx));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule